// File: doc/BRIEF.md
# Slave Stereo Serial Audio Port

This block connects a stereo converter core to a three-wire serial audio bus on which it is always the slave. An external master supplies the bit clock and the word clock. The block samples both of them in its own system-clock domain and finds the active bit-clock edge.

On the receive side, it extracts a left and a right sample from each frame on the serial input and hands the pair to the playback path. On the transmit side, it takes a left/right pair from the record path and shifts it out on the serial output. The output has a separate output-enable so that the pad can share a bus. A 3-bit format code sets three things together: the frame layout (I2S or LSB-justified), the sample length (16 or 18 bits) and the number of bit clocks per frame. A separate pin chooses which bit-clock edge is active.

Samples are carried on an 18-bit parallel bus aligned to the MSB. In the 16-bit formats, the upper 16 bits are used.

Top module: `stereo_serial_port`

## Requirements
- R1: When `rise_active` is 1, serial data and word clock are sampled on rising bit-clock edges; when it is 0, they are sampled on falling edges. Edges of the other polarity move no data.
- R2: The `fmt_sel` code selects bits per channel slot H and word length W as follows: bit 2 = 0 is I2S and bit 2 = 1 is LSB-justified. Bits [1:0] decode as 00 → H=16, W=16; 01 → H=32, W=16; 10 → H=24, W=16 (receive only); 11 → H=32, W=18.
- R3: In I2S layout, the MSB of a word is on the second active edge of its slot, and the remaining bits follow MSB first. Word clock low marks the left slot and high marks the right slot.
- R4: In LSB-justified layout, the word fills the last W active edges of its slot, MSB first, so that the LSB is the final bit before the word clock changes.
- R5: After the right word of a frame completes, `rx_left` and `rx_right` present that frame's pair, with `rx_valid` high for exactly one system clock. Outside that strobe, the outputs hold their values.
- R6: In 16-bit formats, a received word appears on bits [17:2] and bits [1:0] are zero. Serial input bits outside the word positions have no effect on the received words.
- R7: Transmit words are placed in the same positions that R3 and R4 give for reception, MSB first, starting from bit 17 of the parallel word.
- R8: Every transmitted position that carries no word bit is driven as 0.
- R9: `tx_left` and `tx_right` are both captured at the moment the first bit of the left word is launched. Changes after that moment do not affect the frame being sent.
- R10: In the two H=24 codes (x10), `ser_out` stays 0 and `ser_oe` stays low.
- R11: `ser_oe` is high exactly when `out_drive` is 1 and the code is not a receive-only code.
- R12: `ser_out` changes only in the system-clock cycle that follows a detected active bit-clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_clk | input | 1 | Bit clock from the bus master |
| frame_clk | input | 1 | Word clock: 0 for the left slot, 1 for the right slot |
| ser_in | input | 1 | Serial receive data |
| rise_active | input | 1 | 1: rising bit-clock edge active; 0: falling edge active |
| fmt_sel | input | 3 | Layout, word length and slot length code |
| out_drive | input | 1 | Enables the serial output driver |
| tx_left | input | 18 | Left sample to transmit, MSB aligned |
| tx_right | input | 18 | Right sample to transmit, MSB aligned |
| ser_out | output | 1 | Serial transmit data |
| ser_oe | output | 1 | Output enable for the serial data pad |
| rx_left | output | 18 | Received left sample |
| rx_right | output | 18 | Received right sample |
| rx_valid | output | 1 | One-cycle strobe when a new pair is presented |

## Verification
Every one of the eight format codes runs under both active-edge polarities. Each run streams several frames of random words. The slot positions that carry no word are filled with random bits, so a receiver that reads the wrong window or shifts by one bit shows a corrupted word. The bench also reports an inverted edge choice, because the data then arrives one position late.

Directed words with set MSB and LSB bits separate MSB-first from LSB-first handling and expose lost 18-bit low bits. The transmit inputs change partway through each right slot, which separates capture at the left-word launch from capture at any later point. The receive-only codes and a run with the driver disabled show whether the output enable and the zero data are kept.

// File: rtl/stereo_serial_port.sv
module stereo_serial_port #(
  parameter int DW = 18,
  parameter int PW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_clk,
  input  logic          frame_clk,
  input  logic          ser_in,
  input  logic          rise_active,
  input  logic [2:0]    fmt_sel,
  input  logic          out_drive,
  input  logic [DW-1:0] tx_left,
  input  logic [DW-1:0] tx_right,
  output logic          ser_out,
  output logic          ser_oe,
  output logic [DW-1:0] rx_left,
  output logic [DW-1:0] rx_right,
  output logic          rx_valid
);
  localparam int SW  = DW - 2;
  localparam int PAD = DW - SW;

  logic          lsb_just, rx_only;
  logic [PW-1:0] half, wlen, start_pos;

  assign lsb_just = fmt_sel[2];
  assign rx_only  = (fmt_sel[1:0] == 2'b10);

  always_comb begin
    case (fmt_sel[1:0])
      2'b00:   half = PW'(16);
      2'b01:   half = PW'(32);
      2'b10:   half = PW'(24);
      default: half = PW'(32);
    endcase
    wlen      = (fmt_sel[1:0] == 2'b11) ? PW'(DW) : PW'(SW);
    start_pos = lsb_just ? (half - wlen) : PW'(1);
  end

  // input capture and active-edge detection
  logic bck_r, bck_rr, ws_r, sdi_r, act;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bck_r <= 1'b0; bck_rr <= 1'b0; ws_r <= 1'b0; sdi_r <= 1'b0;
    end else begin
      bck_r <= bit_clk; bck_rr <= bck_r; ws_r <= frame_clk; sdi_r <= ser_in;
    end
  end
  assign act = rise_active ? (bck_r & ~bck_rr) : (~bck_r & bck_rr);

  // slot position tracking
  logic          ws_prev;
  logic [PW-1:0] pos, p, nxt;
  logic          last, nch;

  assign p    = (ws_r != ws_prev) ? '0 : ((&pos) ? pos : pos + PW'(1));
  assign last = (p == half - PW'(1));
  assign nxt  = last ? '0 : p + PW'(1);
  assign nch  = last ? ~ws_r : ws_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ws_prev <= 1'b0;
      pos     <= '1;
    end else if (act) begin
      ws_prev <= ws_r;
      pos     <= p;
    end
  end

  // receive path
  logic [DW-1:0] rx_sh, left_hold, rx_word, rx_aligned;
  logic [PW-1:0] rx_cnt;
  logic          rx_ch;

  assign rx_word    = {rx_sh[DW-2:0], sdi_r};
  assign rx_aligned = (wlen == PW'(DW)) ? rx_word : {rx_word[SW-1:0], {PAD{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_sh <= '0; rx_cnt <= '0; rx_ch <= 1'b0; left_hold <= '0;
      rx_left <= '0; rx_right <= '0; rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (act) begin
        if (p == start_pos) begin
          rx_sh  <= DW'(sdi_r);
          rx_cnt <= PW'(1);
          rx_ch  <= ws_r;
        end else if (rx_cnt != '0) begin
          rx_sh <= rx_word;
          if (rx_cnt == wlen - PW'(1)) begin
            rx_cnt <= '0;
            if (rx_ch) begin
              rx_left  <= left_hold;
              rx_right <= rx_aligned;
              rx_valid <= 1'b1;
            end else begin
              left_hold <= rx_aligned;
            end
          end else begin
            rx_cnt <= rx_cnt + PW'(1);
          end
        end
      end
    end
  end

  // transmit path
  logic [DW-1:0] tx_sh, r_hold, tx_pick;
  logic [PW-1:0] tx_cnt;
  logic          sdo_q;

  assign tx_pick = nch ? r_hold : tx_left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_sh <= '0; r_hold <= '0; tx_cnt <= '0; sdo_q <= 1'b0;
    end else if (act) begin
      if (!rx_only && nxt == start_pos) begin
        if (!nch) r_hold <= tx_right;
        sdo_q  <= tx_pick[DW-1];
        tx_sh  <= tx_pick << 1;
        tx_cnt <= PW'(1);
      end else if (!rx_only && tx_cnt != '0 && tx_cnt != wlen) begin
        sdo_q  <= tx_sh[DW-1];
        tx_sh  <= tx_sh << 1;
        tx_cnt <= tx_cnt + PW'(1);
      end else begin
        sdo_q  <= 1'b0;
        tx_cnt <= '0;
      end
    end
  end

  assign ser_out = sdo_q & ~rx_only;
  assign ser_oe  = out_drive & ~rx_only;

  AST_VALID_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(act)); // R5
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R5
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> ($stable(rx_left) && $stable(rx_right))); // R5
  AST_NO_LAUNCH_RXONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rx_only) && $past(act)) |-> !sdo_q); // R10
  AST_SDO_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(act) |-> $stable(sdo_q)); // R12
  AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt == '0) |-> !sdo_q); // R8
endmodule

// File: tb/stereo_serial_port_test.sv
module stereo_serial_port_test;
  localparam int NF = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bit_clk = 1'b0, frame_clk = 1'b1, ser_in = 1'b0, rise_active = 1'b1, out_drive = 1'b1;
  logic [2:0] fmt_sel = 3'd0;
  logic [17:0] tx_left = '0, tx_right = '0;
  logic ser_out, ser_oe, rx_valid;
  logic [17:0] rx_left, rx_right;

  int checks = 0, errors = 0, vcount = 0;
  bit done = 1'b0;
  bit sbits[0:511], wsb[0:511], txexp[0:511];
  logic [17:0] eL[0:NF-1], eR[0:NF-1], TL[0:NF], TR[0:NF];

  always #2.5 clk = ~clk;

  stereo_serial_port uut (
    .clk(clk), .rst_n(rst_n), .bit_clk(bit_clk), .frame_clk(frame_clk), .ser_in(ser_in),
    .rise_active(rise_active), .fmt_sel(fmt_sel), .out_drive(out_drive),
    .tx_left(tx_left), .tx_right(tx_right), .ser_out(ser_out), .ser_oe(ser_oe),
    .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid));

  function automatic logic [17:0] align(input logic [17:0] v, input bit w18);
    return w18 ? v : {v[17:2], 2'b00};
  endfunction

  // R3/R4/R5/R6 received pairs, skipping the lead slot's pair
  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      vcount++;
      if (vcount > 1 && vcount - 2 < NF) begin
        checks++;
        if (rx_left !== eL[vcount-2] || rx_right !== eR[vcount-2]) begin
          errors++;
          $display("FAIL R3/R4/R5/R6 fmt=%0d frame %0d: got %h/%h expected %h/%h",
                   fmt_sel, vcount-2, rx_left, rx_right, eL[vcount-2], eR[vcount-2]);
        end
      end
    end
  end

  task automatic run(input logic [2:0] m, input bit er, input bit en);
    int H, W, st, T, lim, bad_tx, bad_oe, first_j;
    bit i2s, rxo, got;
    logic [17:0] L, R;
    i2s = !m[2];
    rxo = (m[1:0] == 2'b10);
    case (m[1:0])
      2'b00: begin H = 16; W = 16; end
      2'b01: begin H = 32; W = 16; end
      2'b10: begin H = 24; W = 16; end
      default: begin H = 32; W = 18; end
    endcase
    st = i2s ? 1 : H - W;
    T = H * (2 + 2 * NF);
    for (int j = 0; j < T; j++) begin
      sbits[j] = 1'($urandom);
      wsb[j] = ((j / H) % 2 == 0);
      txexp[j] = 1'b0;
    end
    for (int k = 0; k <= NF; k++) begin
      TL[k] = 18'($urandom);
      TR[k] = 18'($urandom);
    end
    if (m == 3'd3) begin TL[0] = 18'h20001; TR[0] = 18'h3FFFF; end
    for (int k = 0; k < NF; k++) begin
      L = 18'($urandom);
      R = 18'($urandom);
      if (k == 0) begin L = 18'h20001; R = 18'h1FFFE; end
      eL[k] = align(L, W == 18);
      eR[k] = align(R, W == 18);
      for (int i = 0; i < W; i++) begin
        sbits[H*(1+2*k)+st+i] = L[17-i];
        sbits[H*(2+2*k)+st+i] = R[17-i];
        if (!rxo) begin
          txexp[H*(1+2*k)+st+i] = TL[k][17-i];
          txexp[H*(2+2*k)+st+i] = TR[k][17-i];
        end
      end
    end
    fmt_sel = m; rise_active = er; out_drive = en;
    bit_clk = er ? 1'b0 : 1'b1;
    frame_clk = 1'b1; ser_in = 1'b0;
    tx_left = TL[0]; tx_right = TR[0];
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    vcount = 0;
    repeat (2) @(negedge clk);
    checks++;
    if (rx_valid !== 1'b0 || rx_left !== 18'h0 || rx_right !== 18'h0 || ser_out !== 1'b0) begin
      errors++;
      $display("FAIL R5 reset state fmt=%0d: got v=%b l=%h r=%h out=%b expected 0", m, rx_valid, rx_left, rx_right, ser_out);
    end
    bad_tx = 0; bad_oe = 0; first_j = -1;
    lim = H * (1 + 2 * NF) + (i2s ? 1 : 0);
    for (int j = 0; j < T; j++) begin
      frame_clk = wsb[j];
      ser_in = sbits[j];
      if (j % H == 2 && (j / H) % 2 == 0 && j / H >= 2) begin
        tx_left = TL[(j / H - 2) / 2 + 1];
        tx_right = TR[(j / H - 2) / 2 + 1];
      end
      repeat (4) @(negedge clk);
      got = ser_out;
      if (j < lim && got !== txexp[j]) begin
        bad_tx++;
        if (first_j < 0) first_j = j;
      end
      if (ser_oe !== (en && !rxo)) bad_oe++;
      bit_clk = ~bit_clk;
      repeat (4) @(negedge clk);
      bit_clk = ~bit_clk;
    end
    repeat (4) @(negedge clk);
    checks++; // R1 R7 R8 R9 R10 transmit stream
    if (bad_tx != 0) begin
      errors++;
      $display("FAIL R7/R8/R9/R10 fmt=%0d edge=%0d: %0d bad bits, first at %0d got %b expected %b",
               m, er, bad_tx, first_j, ~txexp[first_j], txexp[first_j]);
    end
    checks++; // R11 output enable
    if (bad_oe != 0) begin
      errors++;
      $display("FAIL R11 fmt=%0d en=%0d: oe wrong on %0d bits, got %b expected %b",
               m, en, bad_oe, ser_oe, en && !rxo);
    end
    checks++; // R1 R2 frame count
    if (vcount != NF + 1) begin
      errors++;
      $display("FAIL R1/R2 fmt=%0d edge=%0d: got %0d strobes expected %0d", m, er, vcount, NF + 1);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int m = 0; m < 8; m++)
      for (int e = 0; e < 2; e++)
        run(3'(m), 1'(e), 1'b1);
    run(3'd1, 1'b1, 1'b0);
    run(3'd6, 1'b0, 1'b0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule